// File: doc/BRIEF.md
# Two-Source Clock Selector with Committed Switch

This block drives one output clock from either of two free-running source clocks. Source 0 is normally a PLL output and source 1 the main system clock. Software picks the wanted source by writing a code into a staging register. That write alone does nothing to the output. The change is committed only when software writes a 0 and then a 1 to a separate update bit.

A committed switch runs as a break-before-make handshake between the two clock domains. The source in use is gated off on one of its own falling edges, after a two-flop synchronizer. The other source is gated on only once its own domain has seen the first gate go off. This way the output never carries a runt pulse.

A busy flag can be read back while a switch is in flight. A commit that arrives during a switch is held and then applied once the running switch has finished.

Top module: `refclk_switch`

## Requirements
- R1: After reset the staged code reads 0, the update bit reads 0, busy reads 0, and the output follows source 0 with no update sequence.
- R2: Register address 0 holds the staged code in bits [1:0]. It is written from wr_data[1:0], and bits [31:2] always read as zero.
- R3: Writing the staged code without a commit leaves the output on its current source.
- R4: Address 1 bit 0 is the stored update bit and reads back as written. A commit happens only when a write takes this bit from 0 to 1. Writing 1 while it is already 1 causes no switch.
- R5: A commit with staged code 0 makes the output follow source 0. A commit with code 1 makes it follow source 1.
- R6: A commit with staged code 2 or 3 leaves the output on its current source, and busy stays 0.
- R7: The two source gates are never open together. No output high or low phase is shorter than half a period of the faster source.
- R8: Address 1 bit 1 reads 1 from the commit cycle of a switch to a different source until the new source drives the output, and reads 0 otherwise.
- R9: A commit made while busy reads 1 is held. It is applied after the running switch completes, and the last such commit wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cfg | input | 1 | Register interface clock |
| rst_n | input | 1 | Synchronous active-low reset, in the clk_cfg domain |
| clk_src0 | input | 1 | Source clock 0 (PLL output), selected by code 0 |
| clk_src1 | input | 1 | Source clock 1 (main clock), selected by code 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 is the staged code, 1 is the update bit |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address, same map as wr_addr |
| rd_data | output | 32 | Combinational readback of the addressed register |
| clk_out | output | 1 | Gated output clock |

## Verification
The assertions take for granted that both source clocks keep toggling whenever a commit is made or still pending. They also assume reset is held long enough for each source domain to see it through its reset synchronizer. The bench meets both assumptions: the two sources run without a break at unrelated periods of 10 ns and 14 ns, and reset is held for twenty register-clock cycles. Random stimulus waits until busy has cleared before it measures which source the output follows. Only the directed pending-commit case issues writes while a switch is in flight.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
// Shared constants for the two-source clock selector: register map,
// field positions and structural sizes.
package clksel_pkg;
    localparam int NSRC        = 2;   // number of source clocks
    localparam int SEL_W       = 2;   // width of the staged code field
    localparam int DATA_W      = 32;  // register data width
    localparam int ADDR_W      = 1;   // register address width
    localparam int IDX_W       = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int SYNC_STAGES = 2;   // flops per synchronizer

    localparam logic [ADDR_W-1:0] REG_SEL = 1'b0;  // staged code register
    localparam logic [ADDR_W-1:0] REG_UPD = 1'b1;  // update / status register
    localparam int UPD_BIT  = 0;
    localparam int BUSY_BIT = 1;
endpackage

// File: rtl/clksel_sync.sv
`timescale 1ns/1ps
// Multi-flop level synchronizer. FALLING picks the capture edge.
// RST_VAL is loaded on a synchronous active-low reset.
// Assumes STAGES >= 2 and that d is a slow level signal.
module clksel_sync #(
    parameter int STAGES  = 2,
    parameter bit FALLING = 1'b0,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    generate
        if (FALLING) begin : g_fall
            // Shift the input through the chain on the falling edge.
            always_ff @(negedge clk) begin
                if (!rst_n) ff <= {STAGES{RST_VAL}};
                else        ff <= {ff[STAGES-2:0], d};
            end
        end else begin : g_rise
            // Shift the input through the chain on the rising edge.
            always_ff @(posedge clk) begin
                if (!rst_n) ff <= {STAGES{RST_VAL}};
                else        ff <= {ff[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/clksel_branch.sv
`timescale 1ns/1ps
// One gate branch of the glitch-free mux. The gate opens only when this
// source is wanted and every other branch reports closed. The request is
// moved into this clock's domain on falling edges, so the enable changes
// only while the clock is low.
// Assumes clk keeps running while a switch is in progress.
module clksel_branch #(
    parameter int STAGES = 2,
    parameter bit RST_ON = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic others_on,
    output logic en_o
);
    logic req;

    // Open request: wanted here and nobody else holds the output.
    always_comb req = want & ~others_on;

    clksel_sync #(.STAGES(STAGES), .FALLING(1'b1), .RST_VAL(RST_ON)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (req),
        .q    (en_o)
    );
endmodule

// File: rtl/clksel_regs.sv
`timescale 1ns/1ps
// Register side of the selector, in the clk_cfg domain. It keeps the staged
// code and the update bit, detects a commit as a 0->1 write of the update
// bit, holds commits made while busy, and drives the committed target as a
// one-hot wanted vector. Busy compares the target with the gate states that
// have been synchronized back from the source domains.
module clksel_regs
    import clksel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NSRC-1:0]   en_seen,
    output logic [NSRC-1:0]   want
);
    logic [SEL_W-1:0] stg_q;
    logic             upd_q;
    logic [IDX_W-1:0] tgt_q;
    logic             pend_q;
    logic [IDX_W-1:0] pend_idx_q;
    logic             commit_ev;
    logic             code_ok;
    logic             settled;
    logic             busy;
    logic             unused_wr;

    assign unused_wr = ^wr_data[DATA_W-1:SEL_W];

    // Commit detection and decode of the wanted source and busy state.
    always_comb begin
        commit_ev = wr_en && (wr_addr == REG_UPD) && wr_data[UPD_BIT] && !upd_q;
        code_ok   = (stg_q < SEL_W'(NSRC));
        want      = NSRC'(1) << tgt_q;
        settled   = (en_seen == want);
        busy      = !settled || pend_q;
    end

    // Register writes, target commit and held-commit replay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q      <= '0;
            upd_q      <= 1'b0;
            tgt_q      <= '0;
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
        end else begin
            if (wr_en && wr_addr == REG_SEL) stg_q <= wr_data[SEL_W-1:0];
            if (wr_en && wr_addr == REG_UPD) upd_q <= wr_data[UPD_BIT];
            if (commit_ev && code_ok) begin
                if (busy) begin
                    pend_q     <= 1'b1;
                    pend_idx_q <= stg_q[IDX_W-1:0];
                end else begin
                    tgt_q <= stg_q[IDX_W-1:0];
                end
            end else if (pend_q && settled) begin
                tgt_q  <= pend_idx_q;
                pend_q <= 1'b0;
            end
        end
    end

    // Readback multiplexer; unused bits read as zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_SEL: rd_data[SEL_W-1:0] = stg_q;
            default: begin
                rd_data[UPD_BIT]  = upd_q;
                rd_data[BUSY_BIT] = busy;
            end
        endcase
    end

    AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_SEL && !pend_q) |=> $stable(tgt_q)); // R3
    AST_NO_SPURIOUS_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_ev && !pend_q) |=> $stable(tgt_q)); // R4
    AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ev && !code_ok && !pend_q) |=> ($stable(tgt_q) && !pend_q)); // R6
    AST_HELD_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ev && code_ok && busy) |=> pend_q); // R9
endmodule

// File: rtl/refclk_switch.sv
`timescale 1ns/1ps
// Two-source clock selector with committed, glitch-free switching.
// Each source domain has its own reset synchronizer and gate branch. The
// branch enables come back into clk_cfg for the busy status.
// Assumes both sources run while a switch is committed or pending, and that
// rst_n is held for several periods of the slowest source.
module refclk_switch
    import clksel_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic              clk_cfg,
    input  logic              rst_n,
    input  logic              clk_src0,
    input  logic              clk_src1,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              clk_out
);
    logic [NSRC-1:0] src_clk;
    logic [NSRC-1:0] want;
    logic [NSRC-1:0] en;
    logic [NSRC-1:0] en_seen;
    logic [NSRC-1:0] dom_rst_n;

    assign src_clk = {clk_src1, clk_src0};

    clksel_regs u_regs (
        .clk    (clk_cfg),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .en_seen(en_seen),
        .want   (want)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam logic [NSRC-1:0] SELF = NSRC'(1) << i;

        clksel_sync #(.STAGES(STAGES), .FALLING(1'b0), .RST_VAL(1'b0)) u_rst (
            .clk  (src_clk[i]),
            .rst_n(1'b1),
            .d    (rst_n),
            .q    (dom_rst_n[i])
        );

        clksel_branch #(.STAGES(STAGES), .RST_ON(i == 0)) u_branch (
            .clk      (src_clk[i]),
            .rst_n    (dom_rst_n[i]),
            .want     (want[i]),
            .others_on(|(en & ~SELF)),
            .en_o     (en[i])
        );

        clksel_sync #(.STAGES(STAGES), .FALLING(1'b0), .RST_VAL(i == 0)) u_seen (
            .clk  (clk_cfg),
            .rst_n(rst_n),
            .d    (en[i]),
            .q    (en_seen[i])
        );
    end

    // Gated OR of the sources; each gate only moves while its clock is low.
    always_comb clk_out = |(src_clk & en);

    AST_BREAK_BEFORE_MAKE: assert property (@(posedge clk_cfg) disable iff (!rst_n)
        $onehot0(en)); // R7
endmodule

// File: tb/tb_refclk_switch.sv
`timescale 1ns/1ps
module tb_refclk_switch;
    logic        clk_cfg = 1'b0;
    logic        rst_n   = 1'b0;
    logic        clk_src0 = 1'b0;
    logic        clk_src1 = 1'b0;
    logic        wr_en   = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic        clk_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    refclk_switch dut (
        .clk_cfg(clk_cfg), .rst_n(rst_n), .clk_src0(clk_src0), .clk_src1(clk_src1),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .clk_out(clk_out)
    );

    always #2 clk_cfg  = ~clk_cfg;
    always #5 clk_src0 = ~clk_src0;
    always #7 clk_src1 = ~clk_src1;

    // Pulse width monitor for R7.
    bit  mon_on = 1'b0;
    bit  have_t = 1'b0;
    real last_t = 0.0;
    real min_w  = 1.0e9;
    always @(clk_out) begin
        if (mon_on) begin
            if (have_t && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
            last_t = $realtime;
            have_t = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk_cfg); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input bit a, output logic [31:0] v);
        @(negedge clk_cfg);
        rd_addr = a;
        #0.1;
        v = rd_data;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 400; k++) begin
            rd(1'b1, v);
            if (!v[1]) return;
        end
    endtask

    // 0: follows source 0, 1: follows source 1, 2: neither.
    task automatic measure(output int src);
        int ma = 0;
        int mb = 0;
        #0.5;
        for (int k = 0; k < 140; k++) begin
            if (clk_out !== clk_src0) ma++;
            if (clk_out !== clk_src1) mb++;
            #1;
        end
        src = (ma == 0) ? 0 : ((mb == 0) ? 1 : 2);
    endtask

    function automatic int after_commit(int cur, int sel, bit upd_prev, bit upd_new);
        if (upd_new && !upd_prev && sel < 2) return sel;
        return cur;
    endfunction

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int s;
        int src_m;
        int sel_m;
        bit upd_m;
        void'($urandom(32'd7341));
        repeat (20) @(posedge clk_cfg);
        #1 rst_n = 1'b1;
        repeat (12) @(posedge clk_cfg);
        #1 mon_on = 1'b1;

        // R1 reset state
        rd(1'b0, v); chk(v == 0, "R1 sel", int'(v), 0);
        rd(1'b1, v); chk(v == 0, "R1 upd/busy", int'(v), 0);
        measure(s); chk(s == 0, "R1 source", s, 0);

        // R2 field width and zero upper bits
        @(posedge clk_cfg); #1;
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, v); chk(v == 32'd3, "R2 all ones", int'(v), 3);
        wr(1'b0, 32'hABCD_0001);
        rd(1'b0, v); chk(v == 32'd1, "R2 mixed", int'(v), 1);

        // R3 staging alone does not switch
        measure(s); chk(s == 0, "R3 staged only", s, 0);

        // R5 / R8 commit to source 1
        wr(1'b1, 32'd0);
        wr(1'b1, 32'd1);
        rd(1'b1, v); chk(v[1] == 1'b1, "R8 busy after commit", int'(v[1]), 1);
        wait_idle();
        rd(1'b1, v); chk(v == 32'd1, "R8 idle + R4 upd readback", int'(v), 1);
        measure(s); chk(s == 1, "R5 to source 1", s, 1);

        // R4 writing 1 again is no commit
        wr(1'b0, 32'd0);
        wr(1'b1, 32'd1);
        rd(1'b1, v); chk(v[1] == 1'b0, "R4 no busy", int'(v[1]), 0);
        measure(s); chk(s == 1, "R4 no switch", s, 1);

        // R6 reserved codes
        for (int c = 2; c < 4; c++) begin
            wr(1'b0, 32'(c));
            wr(1'b1, 32'd0);
            wr(1'b1, 32'd1);
            rd(1'b1, v); chk(v[1] == 1'b0, "R6 busy stays low", int'(v[1]), 0);
            measure(s); chk(s == 1, "R6 reserved keeps source", s, 1);
        end

        // R5 back to source 0
        wr(1'b0, 32'd0);
        wr(1'b1, 32'd0);
        wr(1'b1, 32'd1);
        wait_idle();
        measure(s); chk(s == 0, "R5 to source 0", s, 0);

        // R9 commit during a switch is held and applied afterwards
        wr(1'b0, 32'd1);
        wr(1'b1, 32'd0);
        wr(1'b1, 32'd1);
        wr(1'b0, 32'd0);
        wr(1'b1, 32'd0);
        wr(1'b1, 32'd1);
        rd(1'b1, v); chk(v[1] == 1'b1, "R9 busy while held", int'(v[1]), 1);
        wait_idle();
        measure(s); chk(s == 0, "R9 held commit applied", s, 0);

        // Random operations, each followed by settling and a check
        src_m = 0; sel_m = 0; upd_m = 1'b1;
        for (int it = 0; it < 40; it++) begin
            int op = int'($urandom % 3);
            logic [31:0] d = $urandom;
            @(posedge clk_cfg); #1;
            if (op == 0) begin
                wr(1'b0, d);
                sel_m = int'(d[1:0]);
            end else begin
                bit nb = (op == 2);
                wr(1'b1, {d[31:1], nb});
                src_m = after_commit(src_m, sel_m, upd_m, nb);
                upd_m = nb;
            end
            wait_idle();
            rd(1'b0, v); chk(v == 32'(sel_m), "R2 random sel", int'(v), sel_m);
            rd(1'b1, v); chk(v == {31'd0, upd_m}, "R4 random upd", int'(v), int'(upd_m));
            measure(s); chk(s == src_m, "R5 random source", s, src_m);
        end

        // R7 pulse width over the whole run (scaled by 10)
        chk(min_w >= 4.9, "R7 min pulse", $rtoi(min_w * 10.0), 50);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule